// File: doc/BRIEF.md
# Command Post Queue Register Interface

This block is the device-side register front end of a storage controller's simple transport. A host on a 32-bit word-access register bus posts command addresses into an inbound queue and collects finished command tags from an outbound queue. The controller's own logic sits on a local port: it drains the inbound queue and feeds completions into the outbound queue. The local port also receives a flag meaning "configuration table updated", and a sticky flag that reports a dropped host post.

Three host registers sit beside the two queue ports: a doorbell, a raw interrupt status and an interrupt mask. One level interrupt output goes high when completions are waiting and the host has unmasked that condition. The status bit for "completions waiting" sits at bit 3 or bit 2, chosen by the parameter `NE_BIT`, so that two board variants can be served. Queue depth is the parameter `DEPTH`, which must be a power of two.

Top module: `cmdq_regs`

## Requirements
- R1: After reset both queues are empty, the mask register (0x34) reads 0xFFFFFFFF, and `irq`, `l_in_valid`, `l_db_cfg`, `l_in_ovf` and `l_out_full` are all low.
- R2: A host write to 0x40 appends `h_wdata` to the inbound queue. The local side sees the oldest entry on `l_in_data` while `l_in_valid` is high, and `l_pop` removes it. Entries leave in the order they were written.
- R3: With `DEPTH` (16) entries held, a host write to 0x40 is dropped and `l_in_ovf` goes high. It stays high until reset.
- R4: A host read of 0x44 returns the oldest completion and removes it. If the outbound queue is empty, the read returns 0xFFFFFFFF and changes nothing.
- R5: A completion pushed with `l_push` is stored as `{l_push_tag[31:2], l_push_err, 1'b0}`, so bit 1 flags an error and bit 0 is always clear.
- R6: A read of 0x30 returns a 1 at bit `NE_BIT` (3 by default) whenever the outbound queue is non-empty, whatever the mask holds. Every other bit reads 0.
- R7: The mask register at 0x34 is a plain 32-bit read/write register. `irq` is high exactly when the outbound queue is non-empty and mask bit `NE_BIT` is 0.
- R8: A host write to 0x20 with bit 0 set makes `l_db_cfg` high. `l_db_ack` clears it, but a set and an acknowledge in the same cycle leave it high. A write to 0x20 with bit 0 clear has no effect. A read of 0x20 returns the flag in bit 0.
- R9: Reads of any offset other than 0x20, 0x30, 0x34, 0x40 and 0x44 return 0, and writes to them change nothing. A read of 0x40 also returns 0.
- R10: `l_out_full` is high while the outbound queue holds `DEPTH` entries, and a push at that point is dropped. A local push and a host pop in the same cycle both take effect.
- R11: A host post to 0x40 and an `l_pop` in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host word write strobe |
| h_rd | input | 1 | Host word read strobe; a read of 0x44 pops at the clock edge |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, combinational from `h_addr` |
| irq | output | 1 | Level interrupt to host |
| l_in_valid | output | 1 | Inbound queue non-empty |
| l_in_data | output | 32 | Oldest inbound command address |
| l_pop | input | 1 | Remove oldest inbound entry |
| l_in_ovf | output | 1 | Sticky: a host post was dropped |
| l_push | input | 1 | Push a completion |
| l_push_tag | input | 32 | Completion tag; bits 1:0 are replaced |
| l_push_err | input | 1 | Error flag placed in tag bit 1 |
| l_out_full | output | 1 | Outbound queue full |
| l_db_cfg | output | 1 | Sticky configuration-updated doorbell |
| l_db_ack | input | 1 | Clears `l_db_cfg` |

## Verification
Each queue is shared by two sides. A host pop of the outbound queue can land in the same cycle as a local completion push, and a host post can land in the same cycle as a local pop. A doorbell write can also coincide with its acknowledge. The bench drives each such pair in the same cycle, on purpose. It then judges the result by reading the queue back in full, checking the order, the contents and the empty marker. For the doorbell it checks that the flag stays set.

// File: rtl/cmdq_regs.sv
module cmdq_regs #(
  parameter int DEPTH  = 16,
  parameter int NE_BIT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_wr,
  input  logic        h_rd,
  input  logic [7:0]  h_addr,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  output logic        irq,
  output logic        l_in_valid,
  output logic [31:0] l_in_data,
  input  logic        l_pop,
  output logic        l_in_ovf,
  input  logic        l_push,
  input  logic [31:0] l_push_tag,
  input  logic        l_push_err,
  output logic        l_out_full,
  output logic        l_db_cfg,
  input  logic        l_db_ack
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULLC = (PW+1)'(DEPTH);
  localparam logic [7:0] A_DB = 8'h20, A_ST = 8'h30, A_MK = 8'h34,
                         A_IN = 8'h40, A_OUT = 8'h44;

  logic [31:0]   iq [DEPTH];
  logic [31:0]   oq [DEPTH];
  logic [PW-1:0] iq_wp, iq_rp, oq_wp, oq_rp;
  logic [PW:0]   iq_cnt, oq_cnt;
  logic [31:0]   mask;

  wire iq_push = h_wr && h_addr == A_IN && iq_cnt != FULLC;
  wire iq_pop  = l_pop && iq_cnt != '0;
  wire oq_push = l_push && oq_cnt != FULLC;
  wire oq_pop  = h_rd && h_addr == A_OUT && oq_cnt != '0;
  wire oq_ne   = oq_cnt != '0;
  wire db_set  = h_wr && h_addr == A_DB && h_wdata[0];

  assign l_in_valid = iq_cnt != '0;
  assign l_in_data  = iq[iq_rp];
  assign l_out_full = oq_cnt == FULLC;
  assign irq        = oq_ne && !mask[NE_BIT];

  always_ff @(posedge clk) begin
    if (iq_push) iq[iq_wp] <= h_wdata;
    if (oq_push) oq[oq_wp] <= {l_push_tag[31:2], l_push_err, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iq_wp <= '0; iq_rp <= '0; iq_cnt <= '0;
      oq_wp <= '0; oq_rp <= '0; oq_cnt <= '0;
      mask <= '1; l_db_cfg <= 1'b0; l_in_ovf <= 1'b0;
    end else begin
      if (iq_push) iq_wp <= iq_wp + 1'b1;
      if (iq_pop)  iq_rp <= iq_rp + 1'b1;
      case ({iq_push, iq_pop})
        2'b10:   iq_cnt <= iq_cnt + 1'b1;
        2'b01:   iq_cnt <= iq_cnt - 1'b1;
        default: ;
      endcase
      if (oq_push) oq_wp <= oq_wp + 1'b1;
      if (oq_pop)  oq_rp <= oq_rp + 1'b1;
      case ({oq_push, oq_pop})
        2'b10:   oq_cnt <= oq_cnt + 1'b1;
        2'b01:   oq_cnt <= oq_cnt - 1'b1;
        default: ;
      endcase
      if (h_wr && h_addr == A_IN && iq_cnt == FULLC) l_in_ovf <= 1'b1;
      if (h_wr && h_addr == A_MK) mask <= h_wdata;
      if (db_set) l_db_cfg <= 1'b1;
      else if (l_db_ack) l_db_cfg <= 1'b0;
    end
  end

  always_comb begin
    case (h_addr)
      A_DB:    h_rdata = {31'b0, l_db_cfg};
      A_ST:    h_rdata = 32'(oq_ne) << NE_BIT;
      A_MK:    h_rdata = mask;
      A_OUT:   h_rdata = oq_ne ? oq[oq_rp] : 32'hFFFF_FFFF;
      default: h_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmdq_regs_chk.sv
module cmdq_regs_chk #(
  parameter int NE_BIT = 3,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_wr,
  input logic          h_rd,
  input logic [7:0]    h_addr,
  input logic [31:0]   h_wdata,
  input logic [31:0]   h_rdata,
  input logic          irq,
  input logic          l_db_cfg,
  input logic          l_db_ack,
  input logic          l_in_ovf,
  input logic [CW-1:0] oq_cnt
);
  wire rd_known = h_addr == 8'h20 || h_addr == 8'h30 || h_addr == 8'h34 || h_addr == 8'h44;

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_addr == 8'h44 && oq_cnt == '0) |-> h_rdata == 32'hFFFF_FFFF); // R4
  AST_TAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_addr == 8'h44 && oq_cnt != '0) |-> !h_rdata[0]); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    l_in_ovf |=> l_in_ovf); // R3
  AST_MASK_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == 8'h34 && h_wdata[NE_BIT]) |=> !irq); // R7
  AST_DB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == 8'h20 && h_wdata[0]) |=> l_db_cfg); // R8
  AST_DB_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (l_db_ack && !(h_wr && h_addr == 8'h20 && h_wdata[0])) |=> !l_db_cfg); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && !rd_known) |-> h_rdata == '0); // R9
endmodule

bind cmdq_regs cmdq_regs_chk #(.NE_BIT(NE_BIT), .CW(PW+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
  .h_wdata(h_wdata), .h_rdata(h_rdata), .irq(irq), .l_db_cfg(l_db_cfg),
  .l_db_ack(l_db_ack), .l_in_ovf(l_in_ovf), .oq_cnt(oq_cnt));

// File: tb/cmdq_regs_test.sv
module cmdq_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  localparam logic [73:0] VEC [NV] = '{
    {2'd1, 8'h34, 32'h0,         32'hFFFF_FFFF},
    {2'd1, 8'h30, 32'h0,         32'h0},
    {2'd1, 8'h44, 32'h0,         32'hFFFF_FFFF},
    {2'd1, 8'h20, 32'h0,         32'h0},
    {2'd0, 8'h20, 32'h1,         32'h0},
    {2'd1, 8'h20, 32'h0,         32'h1},
    {2'd0, 8'h34, 32'h0,         32'h0},
    {2'd1, 8'h34, 32'h0,         32'h0},
    {2'd0, 8'h38, 32'hFFFF_FFFF, 32'h0},
    {2'd1, 8'h34, 32'h0,         32'h0},
    {2'd0, 8'h50, 32'h1234_5678, 32'h0},
    {2'd1, 8'h50, 32'h0,         32'h0},
    {2'd1, 8'h40, 32'h0,         32'h0},
    {2'd1, 8'h10, 32'h0,         32'h0}
  };

  logic clk = 0, rst_n = 0;
  logic h_wr = 0, h_rd = 0, l_pop = 0, l_push = 0, l_push_err = 0, l_db_ack = 0;
  logic [7:0] h_addr = 0;
  logic [31:0] h_wdata = 0, l_push_tag = 0;
  logic [31:0] h_rdata, l_in_data;
  logic irq, l_in_valid, l_in_ovf, l_out_full, l_db_cfg;
  int n_chk = 0, n_bad = 0;
  logic [31:0] d;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdq_regs uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); h_wr = 1; h_addr = a; h_wdata = v;
    @(negedge clk); h_wr = 0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); h_rd = 1; h_addr = a; #1 v = h_rdata;
    @(negedge clk); h_rd = 0;
  endtask

  task automatic lpush(input logic [31:0] t, input logic e);
    @(negedge clk); l_push = 1; l_push_tag = t; l_push_err = e;
    @(negedge clk); l_push = 0;
  endtask

  task automatic lpop();
    @(negedge clk); l_pop = 1;
    @(negedge clk); l_pop = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!irq && !l_in_valid && !l_db_cfg && !l_in_ovf && !l_out_full, "R1 reset outputs",
        {27'b0, irq, l_in_valid, l_db_cfg, l_in_ovf, l_out_full}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][73:72] == 2'd0) hwrite(VEC[i][71:64], VEC[i][63:32]);
      else begin
        hread(VEC[i][71:64], d);
        chk(d == VEC[i][31:0], "R1/R6/R7/R8/R9 vector read", d, VEC[i][31:0]);
      end
    end

    // R2 ordering
    hwrite(8'h40, 32'hA000_0000);
    hwrite(8'h40, 32'hA000_0004);
    chk(l_in_valid && l_in_data == 32'hA000_0000, "R2 first", l_in_data, 32'hA000_0000);
    lpop();
    chk(l_in_valid && l_in_data == 32'hA000_0004, "R2 second", l_in_data, 32'hA000_0004);
    lpop();
    chk(!l_in_valid, "R2 empty", {31'b0, l_in_valid}, 32'h0);

    // R3 overflow
    for (int i = 0; i < 16; i++) hwrite(8'h40, 32'h1000 + 32'(i*4));
    chk(!l_in_ovf, "R3 no ovf at full", {31'b0, l_in_ovf}, 32'h0);
    hwrite(8'h40, 32'hDEAD_0000);
    chk(l_in_ovf, "R3 ovf set", {31'b0, l_in_ovf}, 32'h1);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (l_in_valid) begin
        chk(l_in_data == 32'h1000 + 32'(n*4), "R3 kept entries", l_in_data, 32'h1000 + 32'(n*4));
        n++; lpop();
      end
    end
    chk(n == 16 && l_in_ovf, "R3 dropped and sticky", 32'(n), 32'd16);

    // R4 R5 R6 R7 outbound (mask is 0)
    lpush(32'h0000_0100, 0);
    lpush(32'h0000_0203, 1);
    chk(irq, "R7 irq unmasked", {31'b0, irq}, 32'h1);
    hread(8'h30, d); chk(d == 32'h8, "R6 status bit", d, 32'h8);
    hread(8'h44, d); chk(d == 32'h100, "R4 oldest", d, 32'h100);
    hread(8'h44, d); chk(d == 32'h202, "R5 err flag and bit0", d, 32'h202);
    chk(!irq, "R7 irq drops when empty", {31'b0, irq}, 32'h0);
    hread(8'h44, d); chk(d == 32'hFFFF_FFFF, "R4 empty marker", d, 32'hFFFF_FFFF);

    // R7 mask, R6 raw
    lpush(32'h0000_0300, 0);
    hwrite(8'h34, 32'h8);
    chk(!irq, "R7 masked", {31'b0, irq}, 32'h0);
    hread(8'h30, d); chk(d == 32'h8, "R6 raw under mask", d, 32'h8);
    hwrite(8'h34, 32'hFFFF_FFF7);
    chk(irq, "R7 other bits irrelevant", {31'b0, irq}, 32'h1);
    hread(8'h44, d); chk(d == 32'h300, "R4 drain", d, 32'h300);

    // R8 doorbell
    hwrite(8'h20, 32'h0);
    chk(l_db_cfg, "R8 zero write no effect", {31'b0, l_db_cfg}, 32'h1);
    @(negedge clk); l_db_ack = 1; @(negedge clk); l_db_ack = 0;
    chk(!l_db_cfg, "R8 ack clears", {31'b0, l_db_cfg}, 32'h0);
    @(negedge clk); l_db_ack = 1; h_wr = 1; h_addr = 8'h20; h_wdata = 32'h1;
    @(negedge clk); l_db_ack = 0; h_wr = 0;
    chk(l_db_cfg, "R8 set beats ack", {31'b0, l_db_cfg}, 32'h1);
    hread(8'h20, d); chk(d == 32'h1, "R8 readback", d, 32'h1);

    // R10 same-cycle push and pop
    lpush(32'h0000_0400, 0);
    @(negedge clk); h_rd = 1; h_addr = 8'h44; l_push = 1; l_push_tag = 32'h0000_0500; l_push_err = 0;
    #1 d = h_rdata;
    @(negedge clk); h_rd = 0; l_push = 0;
    chk(d == 32'h400, "R10 concurrent read value", d, 32'h400);
    hread(8'h44, d); chk(d == 32'h500, "R10 concurrent push kept", d, 32'h500);
    hread(8'h44, d); chk(d == 32'hFFFF_FFFF, "R10 then empty", d, 32'hFFFF_FFFF);

    // R10 full
    for (int i = 0; i < 16; i++) lpush(32'h2000 + 32'(i*4), 0);
    chk(l_out_full, "R10 full flag", {31'b0, l_out_full}, 32'h1);
    lpush(32'hBAD0_0000, 0);
    for (int i = 0; i < 16; i++) begin
      hread(8'h44, d);
      chk(d == 32'h2000 + 32'(i*4), "R10 full contents", d, 32'h2000 + 32'(i*4));
    end
    hread(8'h44, d); chk(d == 32'hFFFF_FFFF, "R10 push at full dropped", d, 32'hFFFF_FFFF);

    // R11 same-cycle post and pop
    hwrite(8'h40, 32'hC000_0000);
    @(negedge clk); h_wr = 1; h_addr = 8'h40; h_wdata = 32'hC000_0010; l_pop = 1;
    @(negedge clk); h_wr = 0; l_pop = 0;
    chk(l_in_valid && l_in_data == 32'hC000_0010, "R11 both applied", l_in_data, 32'hC000_0010);
    lpop();
    chk(!l_in_valid, "R11 one entry left", {31'b0, l_in_valid}, 32'h0);

    done = 1;
    finish_run();
  end
endmodule